// File: doc/BRIEF.md
# Half-Precision Classify, Compare and Min/Max Unit

This block performs the non-arithmetic operations on 16-bit half-precision values held in wider floating-point registers. It can classify one operand, compare two operands for equality, less-than or less-or-equal, pick the minimum or maximum of two operands, and build a value from the magnitude of one operand and a sign taken from the other. The logic that computes these results is combinational. One output register stage with a synchronous active-high reset holds the result and the exception flags, so every result appears one clock after its operands.

Operands arrive at register width (`REG_W`, 64 by default). A half-precision value counts as valid only when every bit above bit 15 is one. Any other operand is read as the canonical quiet NaN. Floating-point results leave the block padded to register width with ones above bit 15. Integer results (the class mask and the compare outcomes) leave it zero-extended.

Top module: `hp_misc_unit`

## Requirements
- R1: `res` and `flags` show the outcome of the operands and operation presented at the previous rising clock edge. While `rst` is high at a rising edge, both outputs become zero.
- R2: Operation code 0 (classify) returns a one-hot mask in `res[9:0]`. The bit set is: 0 for negative infinity, 1 for negative normal, 2 for negative subnormal, 3 for negative zero, 4 for positive zero, 5 for positive subnormal, 6 for positive normal, 7 for positive infinity, 8 for signalling NaN (quiet bit 9 clear), 9 for quiet NaN. All other bits of `res` are zero.
- R3: Operation codes 1 (equal), 2 (less-than) and 3 (less-or-equal) return 1 or 0 in `res[0]`, with all other bits zero, following numeric order. Positive zero and negative zero compare equal.
- R4: A compare with any NaN operand returns 0. Equal sets the invalid flag (`flags[4]`) only when an operand is a signalling NaN. Less-than and less-or-equal set it for any NaN.
- R5: Operation codes 4 (minimum) and 5 (maximum) return the smaller or the larger operand. Negative zero counts as below positive zero in either operand position.
- R6: When exactly one min/max operand is a NaN, the other operand is returned. Any signalling NaN input to min/max sets the invalid flag.
- R7: When both min/max operands are NaN, the result is the canonical quiet NaN 0x7e00. Two quiet NaNs set no flag.
- R8: Operation codes 6, 7 and 8 keep bits 14:0 of operand A. The sign bit is set to B's sign (code 6), to the inverse of B's sign (code 7), or to the xor of both signs (code 8). No flag is raised.
- R9: An operand whose bits above bit 15 are not all one is treated as 0x7e00 by every operation.
- R10: Floating-point results (codes 4 to 8) have all bits above 15 set. Codes 9 to 15 give a zero result and zero flags. `flags[3:0]` is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | REG_W | Operand A, register width |
| opb | input | REG_W | Operand B, register width |
| op_sel | input | 4 | Operation code |
| res | output | REG_W | Registered result |
| flags | output | 5 | Registered exception flags, bit 4 invalid |

## Verification
The two outcomes that can land in the same cycle are a valid numeric result and a raised invalid flag. This happens when min/max is given a signalling NaN beside a number, and when less-than or less-or-equal sees a quiet NaN and returns 0. The bench drives these pairs back to back with ordinary operations. Each clock it judges both the returned number and the flag against a model that computes order from real-valued decoding of the operands, not from bit comparisons.

// File: rtl/hp_misc_pkg.sv
package hp_misc_pkg;

    localparam int HP_W     = 16;
    localparam int EXP_W    = 5;
    localparam int MAN_W    = 10;
    localparam int CLASS_W  = 10;
    localparam int FLAG_W   = 5;
    localparam int FLAG_NV  = 4;
    localparam logic [HP_W-1:0] CANON_NAN = 16'h7e00;

    typedef enum logic [3:0] {
        OP_CLASS = 4'd0,
        OP_FEQ   = 4'd1,
        OP_FLT   = 4'd2,
        OP_FLE   = 4'd3,
        OP_MIN   = 4'd4,
        OP_MAX   = 4'd5,
        OP_SGNJ  = 4'd6,
        OP_SGNJN = 4'd7,
        OP_SGNJX = 4'd8
    } hp_op_e;

    typedef struct packed {
        logic [HP_W-1:0] bits;
        logic            sign;
        logic            is_inf;
        logic            is_norm;
        logic            is_sub;
        logic            is_zero;
        logic            is_snan;
        logic            is_qnan;
    } hp_info_t;

    function automatic hp_info_t hp_decode(input logic [HP_W-1:0] v);
        hp_info_t i;
        logic [EXP_W-1:0] e;
        logic [MAN_W-1:0] m;
        e = v[HP_W-2 -: EXP_W];
        m = v[MAN_W-1:0];
        i.bits    = v;
        i.sign    = v[HP_W-1];
        i.is_inf  = (&e) && (m == '0);
        i.is_snan = (&e) && (m != '0) && !m[MAN_W-1];
        i.is_qnan = (&e) && m[MAN_W-1];
        i.is_zero = (e == '0) && (m == '0);
        i.is_sub  = (e == '0) && (m != '0);
        i.is_norm = (e != '0) && !(&e);
        return i;
    endfunction

    function automatic logic [CLASS_W-1:0] hp_class_mask(input hp_info_t i);
        logic [CLASS_W-1:0] k;
        k    = '0;
        k[0] = i.sign  && i.is_inf;
        k[1] = i.sign  && i.is_norm;
        k[2] = i.sign  && i.is_sub;
        k[3] = i.sign  && i.is_zero;
        k[4] = !i.sign && i.is_zero;
        k[5] = !i.sign && i.is_sub;
        k[6] = !i.sign && i.is_norm;
        k[7] = !i.sign && i.is_inf;
        k[8] = i.is_snan;
        k[9] = i.is_qnan;
        return k;
    endfunction

endpackage

// File: rtl/hp_operand_unbox.sv
module hp_operand_unbox
    import hp_misc_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0] raw,
    output hp_info_t         info
);
    logic [HP_W-1:0] value;

    generate
        if (REG_W > HP_W) begin : g_boxed
            logic box_ok;
            assign box_ok = &raw[REG_W-1:HP_W];
            assign value  = box_ok ? raw[HP_W-1:0] : CANON_NAN;
        end else begin : g_plain
            assign value = raw[HP_W-1:0];
        end
    endgenerate

    assign info = hp_decode(value);
endmodule

// File: rtl/hp_order_unit.sv
module hp_order_unit
    import hp_misc_pkg::*;
(
    input  hp_info_t        a,
    input  hp_info_t        b,
    output logic            eq,
    output logic            lt,
    output logic            le,
    output logic            any_nan,
    output logic            any_snan,
    output logic [HP_W-1:0] min_bits,
    output logic [HP_W-1:0] max_bits
);
    logic a_nan, b_nan, both_zero, lt_raw, eq_raw;
    logic [HP_W-2:0] mag_a, mag_b;

    assign a_nan     = a.is_snan | a.is_qnan;
    assign b_nan     = b.is_snan | b.is_qnan;
    assign any_nan   = a_nan | b_nan;
    assign any_snan  = a.is_snan | b.is_snan;
    assign both_zero = a.is_zero & b.is_zero;
    assign mag_a     = a.bits[HP_W-2:0];
    assign mag_b     = b.bits[HP_W-2:0];

    always_comb begin
        if (a.sign != b.sign)
            lt_raw = a.sign && !both_zero;
        else if (!a.sign)
            lt_raw = mag_a < mag_b;
        else
            lt_raw = mag_a > mag_b;
    end

    assign eq_raw = (a.bits == b.bits) || both_zero;
    assign eq     = eq_raw && !any_nan;
    assign lt     = lt_raw && !any_nan;
    assign le     = (lt_raw || eq_raw) && !any_nan;

    always_comb begin
        if (a_nan && b_nan) begin
            min_bits = CANON_NAN;
            max_bits = CANON_NAN;
        end else if (a_nan) begin
            min_bits = b.bits;
            max_bits = b.bits;
        end else if (b_nan) begin
            min_bits = a.bits;
            max_bits = a.bits;
        end else if (both_zero) begin
            min_bits = a.sign ? a.bits : b.bits;
            max_bits = a.sign ? b.bits : a.bits;
        end else begin
            min_bits = lt_raw ? a.bits : b.bits;
            max_bits = lt_raw ? b.bits : a.bits;
        end
    end
endmodule

// File: rtl/hp_sign_inject.sv
module hp_sign_inject
    import hp_misc_pkg::*;
(
    input  logic [HP_W-1:0] mag_src,
    input  logic            sign_src,
    input  logic [1:0]      mode,
    output logic [HP_W-1:0] out_bits
);
    logic new_sign;

    always_comb begin
        unique case (mode)
            2'd1:    new_sign = !sign_src;
            2'd2:    new_sign = sign_src ^ mag_src[HP_W-1];
            default: new_sign = sign_src;
        endcase
    end

    assign out_bits = {new_sign, mag_src[HP_W-2:0]};
endmodule

// File: rtl/hp_misc_unit.sv
module hp_misc_unit
    import hp_misc_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  opa,
    input  logic [REG_W-1:0]  opb,
    input  logic [3:0]        op_sel,
    output logic [REG_W-1:0]  res,
    output logic [FLAG_W-1:0] flags
);
    hp_info_t        info_a, info_b;
    hp_op_e          op;
    logic            f_eq, f_lt, f_le, nan_any, snan_any;
    logic [HP_W-1:0] min_v, max_v, sgn_v;
    logic [1:0]      sgn_mode;
    logic [REG_W-1:0]  res_d;
    logic [FLAG_W-1:0] flags_d;

    assign op = hp_op_e'(op_sel);

    hp_operand_unbox #(.REG_W(REG_W)) u_unbox_a (.raw(opa), .info(info_a));
    hp_operand_unbox #(.REG_W(REG_W)) u_unbox_b (.raw(opb), .info(info_b));

    hp_order_unit u_order (
        .a(info_a), .b(info_b),
        .eq(f_eq), .lt(f_lt), .le(f_le),
        .any_nan(nan_any), .any_snan(snan_any),
        .min_bits(min_v), .max_bits(max_v)
    );

    assign sgn_mode = (op == OP_SGNJN) ? 2'd1 : (op == OP_SGNJX) ? 2'd2 : 2'd0;

    hp_sign_inject u_sgn (
        .mag_src(info_a.bits), .sign_src(info_b.sign),
        .mode(sgn_mode), .out_bits(sgn_v)
    );

    always_comb begin
        res_d   = '0;
        flags_d = '0;
        case (op)
            OP_CLASS: res_d[CLASS_W-1:0] = hp_class_mask(info_a);
            OP_FEQ: begin
                res_d[0]         = f_eq;
                flags_d[FLAG_NV] = snan_any;
            end
            OP_FLT: begin
                res_d[0]         = f_lt;
                flags_d[FLAG_NV] = nan_any;
            end
            OP_FLE: begin
                res_d[0]         = f_le;
                flags_d[FLAG_NV] = nan_any;
            end
            OP_MIN, OP_MAX: begin
                res_d            = '1;
                res_d[HP_W-1:0]  = (op == OP_MIN) ? min_v : max_v;
                flags_d[FLAG_NV] = snan_any;
            end
            OP_SGNJ, OP_SGNJN, OP_SGNJX: begin
                res_d           = '1;
                res_d[HP_W-1:0] = sgn_v;
            end
            default: begin
                res_d   = '0;
                flags_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res   <= '0;
            flags <= '0;
        end else begin
            res   <= res_d;
            flags <= flags_d;
        end
    end
endmodule

// File: rtl/hp_misc_checker.sv
module hp_misc_checker
    import hp_misc_pkg::*;
#(
    parameter int REG_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [REG_W-1:0]  opa,
    input logic [REG_W-1:0]  opb,
    input logic [3:0]        op_sel,
    input logic [REG_W-1:0]  res,
    input logic [FLAG_W-1:0] flags
);
    localparam logic [REG_W-1:0] LOW_ONES = REG_W'(17'h0ffff);

    logic armed;
    logic a_boxed, b_boxed;
    hp_info_t ca, cb;
    logic both_nan, snan_in, is_cmp, is_mm, is_sgn;

    always_ff @(posedge clk) armed <= !rst;

    assign a_boxed  = &(opa | LOW_ONES);
    assign b_boxed  = &(opb | LOW_ONES);
    assign ca       = hp_decode(a_boxed ? opa[HP_W-1:0] : CANON_NAN);
    assign cb       = hp_decode(b_boxed ? opb[HP_W-1:0] : CANON_NAN);
    assign both_nan = (ca.is_snan | ca.is_qnan) & (cb.is_snan | cb.is_qnan);
    assign snan_in  = ca.is_snan | cb.is_snan;
    assign is_cmp   = op_sel inside {OP_FEQ, OP_FLT, OP_FLE};
    assign is_mm    = op_sel inside {OP_MIN, OP_MAX};
    assign is_sgn   = op_sel inside {OP_SGNJ, OP_SGNJN, OP_SGNJX};

    // R10: only the invalid flag may ever be raised
    a_r10_low_flags_zero: assert property (@(posedge clk) disable iff (rst)
        armed |-> flags[FLAG_NV-1:0] == '0);

    // R2: classify is one-hot within ten bits
    a_r2_class_onehot: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_sel) == OP_CLASS) |->
            ($countones(res) == 1 && res < REG_W'(1024)));

    // R3: compares return a single bit
    a_r3_cmp_single_bit: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(is_cmp)) |-> res <= REG_W'(1));

    // R7: two NaNs into min/max give the canonical NaN
    a_r7_both_nan_canon: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(is_mm) && $past(both_nan)) |-> res[HP_W-1:0] == CANON_NAN);

    // R6: signalling NaN into min/max raises invalid
    a_r6_snan_invalid: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(is_mm) && $past(snan_in)) |-> flags[FLAG_NV]);

    // R8: sign injection keeps operand A's magnitude and raises nothing
    a_r8_magnitude_kept: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(is_sgn) && $past(a_boxed)) |->
            (res[HP_W-2:0] == $past(opa[HP_W-2:0]) && flags == '0));
endmodule

bind hp_misc_unit hp_misc_checker #(.REG_W(REG_W)) u_hp_misc_checker (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb),
    .op_sel(op_sel), .res(res), .flags(flags)
);

// File: tb/hp_misc_unit_bench.sv
module hp_misc_unit_bench;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] opa, opb;
    logic [3:0]   op_sel;
    logic [W-1:0] res;
    logic [4:0]   flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] q_res[$];
    logic [4:0]   q_flg[$];
    string        q_tag[$];

    always #4 clk = ~clk;

    hp_misc_unit #(.REG_W(W)) u_hp_misc_unit (
        .clk(clk), .rst(rst), .opa(opa), .opb(opb),
        .op_sel(op_sel), .res(res), .flags(flags)
    );

    function automatic logic [W-1:0] bx(input logic [15:0] h);
        return {{(W-16){1'b1}}, h};
    endfunction

    function automatic real hval(input logic [15:0] h);
        real r;
        int  e;
        e = int'(h[14:10]);
        if (e == 0) begin
            r = real'(h[9:0]);
            for (int k = 0; k < 24; k++) r = r * 0.5;
        end else begin
            r = real'(1024 + int'(h[9:0]));
            for (int k = 0; k < 25 - e; k++) r = r * 0.5;
            for (int k = 0; k < e - 25; k++) r = r * 2.0;
        end
        return h[15] ? -r : r;
    endfunction

    function automatic bit is_nan(input logic [15:0] h);
        return (h[14:10] == 5'h1f) && (h[9:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [15:0] h);
        return is_nan(h) && !h[9];
    endfunction

    function automatic void model(input logic [W-1:0] ra, input logic [W-1:0] rb,
                                  input logic [3:0] op,
                                  output logic [W-1:0] r, output logic [4:0] f);
        logic [15:0] a, b, pick;
        bit na, nb;
        int idx;
        a  = (ra[W-1:16] == '1) ? ra[15:0] : 16'h7e00;
        b  = (rb[W-1:16] == '1) ? rb[15:0] : 16'h7e00;
        na = is_nan(a);
        nb = is_nan(b);
        r  = '0;
        f  = '0;
        pick = 16'h0;
        case (op)
            4'd0: begin
                if (na)                          idx = is_snan(a) ? 8 : 9;
                else if (a[14:0] == 15'h7c00)    idx = a[15] ? 0 : 7;
                else if (a[14:0] == 0)           idx = a[15] ? 3 : 4;
                else if (a[14:10] == 0)          idx = a[15] ? 2 : 5;
                else                             idx = a[15] ? 1 : 6;
                r = W'(1) << idx;
            end
            4'd1: begin r[0] = !(na || nb) && hval(a) == hval(b); f[4] = is_snan(a) || is_snan(b); end
            4'd2: begin r[0] = !(na || nb) && hval(a) <  hval(b); f[4] = na || nb; end
            4'd3: begin r[0] = !(na || nb) && hval(a) <= hval(b); f[4] = na || nb; end
            4'd4, 4'd5: begin
                if (na && nb)  pick = 16'h7e00;
                else if (na)   pick = b;
                else if (nb)   pick = a;
                else if (hval(a) < hval(b)) pick = (op == 4'd4) ? a : b;
                else if (hval(b) < hval(a)) pick = (op == 4'd4) ? b : a;
                else pick = ((op == 4'd4) == a[15]) ? a : b;
                r = bx(pick);
                f[4] = is_snan(a) || is_snan(b);
            end
            4'd6: r = bx({b[15], a[14:0]});
            4'd7: r = bx({~b[15], a[14:0]});
            4'd8: r = bx({a[15] ^ b[15], a[14:0]});
            default: ;
        endcase
    endfunction

    task automatic check_pending();
        if (q_res.size() > 0) begin
            logic [W-1:0] er;
            logic [4:0]   ef;
            string        t;
            er = q_res.pop_front();
            ef = q_flg.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (res !== er || flags !== ef) begin
                fails++;
                $display("FAIL %s: res=%h flags=%h expected res=%h flags=%h", t, res, flags, er, ef);
            end
        end
    endtask

    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] op, input string tag);
        logic [W-1:0] er;
        logic [4:0]   ef;
        @(negedge clk);
        check_pending();
        opa = a; opb = b; op_sel = op;
        model(a, b, op, er, ef);
        q_res.push_back(er);
        q_flg.push_back(ef);
        q_tag.push_back(tag);
    endtask

    task automatic hv(input logic [15:0] a, input logic [15:0] b,
                      input logic [3:0] op, input string tag);
        issue(bx(a), bx(b), op, tag);
    endtask

    task automatic check_zero_out(input string tag);
        checks++;
        if (res !== '0 || flags !== '0) begin
            fails++;
            $display("FAIL %s: res=%h flags=%h expected res=0 flags=0", tag, res, flags);
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [15:0] specials[8];
        rst = 1'b1; opa = '0; opb = '0; op_sel = '0;
        specials = '{16'h7c01, 16'h7e00, 16'h7c00, 16'hfc00,
                     16'h8000, 16'h0000, 16'h03ff, 16'h83ff};
        repeat (3) @(negedge clk);
        check_zero_out("R1 reset state");
        rst = 1'b0;

        // R2 classify, one per class
        hv(16'hfc00, 16'h0, 4'd0, "R2 -inf");
        hv(16'hbc00, 16'h0, 4'd0, "R2 -normal");
        hv(16'h83ff, 16'h0, 4'd0, "R2 -subnormal");
        hv(16'h8000, 16'h0, 4'd0, "R2 -zero");
        hv(16'h0000, 16'h0, 4'd0, "R2 +zero");
        hv(16'h03ff, 16'h0, 4'd0, "R2 +subnormal");
        hv(16'h3c00, 16'h0, 4'd0, "R2 +normal");
        hv(16'h7c00, 16'h0, 4'd0, "R2 +inf");
        hv(16'h7c01, 16'h0, 4'd0, "R2 snan");
        hv(16'h7e00, 16'h0, 4'd0, "R2 qnan");
        // R3 compares: -1.36 (0xbd71) vs -1.37 (0xbd7b)
        for (int op = 1; op <= 3; op++) begin
            hv(16'hbd71, 16'hbd71, 4'(op), "R3 equal operands");
            hv(16'hbd7b, 16'hbd71, 4'(op), "R3 -1.37 vs -1.36");
            hv(16'h8000, 16'h0000, 4'(op), "R3 signed zeros");
            hv(16'h3c00, 16'hbc00, 4'(op), "R3 mixed sign");
        end
        // R4 compare with NaN, flag and invalid in same cycle
        for (int op = 1; op <= 3; op++) begin
            hv(16'h7e00, 16'h3c00, 4'(op), "R4 quiet NaN compare");
            hv(16'h3c00, 16'h7c01, 4'(op), "R4 signalling NaN compare");
        end
        // R5 ordering incl signed zero both positions
        hv(16'h4100, 16'h3c00, 4'd4, "R5 min");
        hv(16'h4100, 16'h3c00, 4'd5, "R5 max");
        hv(16'hbc00, 16'hc000, 4'd4, "R5 min negatives");
        hv(16'hbc00, 16'hc000, 4'd5, "R5 max negatives");
        hv(16'h8000, 16'h0000, 4'd4, "R5 min -0,+0");
        hv(16'h0000, 16'h8000, 4'd4, "R5 min +0,-0");
        hv(16'h8000, 16'h0000, 4'd5, "R5 max -0,+0");
        hv(16'h0000, 16'h8000, 4'd5, "R5 max +0,-0");
        // R6 single NaN
        hv(16'h7e00, 16'he4d3, 4'd4, "R6 qnan,num min");
        hv(16'h3c00, 16'h7e00, 4'd5, "R6 num,qnan max");
        hv(16'h7c01, 16'h3c00, 4'd5, "R6 snan max returns number with invalid");
        hv(16'h3c00, 16'hfc01, 4'd4, "R6 num,snan min");
        // R7 both NaN
        hv(16'h7e00, 16'hfe55, 4'd5, "R7 two quiet NaNs");
        hv(16'h7c01, 16'h7e00, 4'd4, "R7 snan and qnan");
        // R8 sign injection
        for (int sa = 0; sa < 2; sa++)
            for (int sb = 0; sb < 2; sb++)
                for (int op = 6; op <= 8; op++)
                    hv({1'(sa), 15'h1234}, {1'(sb), 15'h0abc}, 4'(op), "R8 sign injection");
        // R9 improperly boxed operands
        issue({48'h0000_ffff_ffff, 16'h3c00}, bx(16'h3c00), 4'd0, "R9 unboxed classify");
        issue({48'h7fff_ffff_ffff, 16'h3c00}, bx(16'h4000), 4'd4, "R9 unboxed min");
        issue(bx(16'h3c00), 64'h0, 4'd1, "R9 unboxed eq");
        issue(64'h1234, bx(16'h8000), 4'd6, "R9 unboxed sign inject");
        // R10 unused codes
        for (int op = 9; op < 16; op++)
            hv(16'h7c01, 16'h3c00, 4'(op), "R10 unused code");

        // R1 reset in mid-run
        @(negedge clk);
        check_pending();
        opa = bx(16'h3c00); opb = bx(16'h7c01); op_sel = 4'd5;
        rst = 1'b1;
        @(negedge clk);
        check_zero_out("R1 reset mid-run");
        rst = 1'b0;

        // Mixed sweep: specials and random values across all codes
        seed = 32'h1ace_b00c;
        for (int n = 0; n < 600; n++) begin
            logic [15:0] a16, b16;
            logic [3:0]  op;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            a16 = seed[15:0];
            b16 = seed[31:16];
            if (seed[3:2] == 2'b00) a16 = specials[seed[6:4]];
            if (seed[8:7] == 2'b00) b16 = specials[seed[11:9]];
            op = 4'(seed[21:18] % 10);
            hv(a16, b16, op, $sformatf("R%0d sweep op %0d", (op == 0) ? 2 : (op <= 3) ? 3 : (op <= 5) ? 5 : (op <= 8) ? 8 : 10, op));
        end

        @(negedge clk);
        check_pending();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule